// File: doc/BRIEF.md
# Frame-Size-Adaptive Transmit/Receive Queue Pair

This block holds the outgoing and incoming data words of a serial peripheral controller. A host writes words into the transmit queue and reads words from the receive queue. A shift engine pops words from the transmit queue and pushes captured words into the receive queue. Both queues share one physical size of 32 slots. The number of slots actually in use, called the working depth, depends on a wide-queue option and on the programmed frame length.

The working depth and the frame length are captured only when the configuration strobe is pulsed. With the wide-queue option off, each queue holds 4 words. With it on, short frames get 32 words, mid-size frames get 16 and long frames get 8. A word entering either queue is cut down to the captured frame length and zero-extended to 32 bits. A twelve-bit status vector reports, for each direction, whether the queue is full, one short of full, empty, or holding exactly one word. It also carries a sticky receive-overflow bit. All flags come from occupancy counters, so they follow a push or pop on the clock edge that performs it.

Top module: `spiq_pair`

## Requirements
- R1: After reset both queues hold nothing, the working depth is 4, the captured frame length is 32 bits, and `status` equals 0x440: only bit 6 (receive empty) and bit 10 (transmit empty) are set.
- R2: When `cfg_wr` is pulsed with `cfg_big` low, each queue accepts at most 4 words.
- R3: When `cfg_wr` is pulsed with `cfg_big` high, the working depth follows the frame length: 32 for a length of 0 to 8, 16 for 9 to 16, and 8 for 17 and above.
- R4: `cfg_big` and `cfg_flen` are captured only on a cycle with `cfg_wr` high. At any other time, changing them has no effect on depth or masking.
- R5: A host write to the transmit queue while its occupancy is at or above the working depth is dropped. The queue contents and occupancy stay unchanged.
- R6: The full flags assert when occupancy is at or above the working depth: bit 4 for receive, bit 8 for transmit. The full-next flags assert when occupancy equals the depth minus one: bit 5 for receive, bit 9 for transmit.
- R7: The empty flags assert when occupancy is zero: bit 6 for receive, bit 10 for transmit. The empty-next flags assert when occupancy is exactly one: bit 7 for receive, bit 11 for transmit.
- R8: Each queue returns words oldest first. The read data (`rx_rdata`, `eng_tx_data`) shows the oldest word whenever the queue is not empty and reads zero when it is. A read of an empty queue changes nothing.
- R9: An engine push into a full receive queue is dropped and sets bit 2 of `status`. That bit stays set until the host reads the receive queue.
- R10: Stored words keep only the low `cfg_flen` bits and zero-extend the rest. A captured length of 0, or of 32 and above, keeps all 32 bits.
- R11: A push and a pop on the same queue in the same cycle leave its occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration capture strobe |
| cfg_big | input | 1 | Wide-queue option |
| cfg_flen | input | 6 | Frame length in bits |
| tx_wr | input | 1 | Host write to the transmit queue |
| tx_wdata | input | 32 | Host transmit word |
| rx_rd | input | 1 | Host read from the receive queue |
| rx_rdata | output | 32 | Oldest receive word, or zero when the queue is empty |
| eng_tx_pop | input | 1 | Engine pop from the transmit queue |
| eng_tx_data | output | 32 | Oldest transmit word, or zero when the queue is empty |
| eng_rx_push | input | 1 | Engine push into the receive queue |
| eng_rx_data | input | 32 | Engine receive word |
| status | output | 12 | Flag vector; bit positions are given in R6, R7 and R9 |

## Verification
The bench sweeps the frame length over 0 to 34 with the wide option on, plus one setting with it off. For each setting it fills each queue two words past its depth, then drains it one word past empty. The fill shows whether the depth steps and the full boundaries land on the right counts. The drain separates correct ordering from stale or unmasked data and shows how an empty read behaves. During each sweep the configuration inputs are deliberately flipped without a strobe, so that leaking a live input into the depth or the mask shows up as a mismatch. A final mixed push-and-pop pattern separates a correct simultaneous update from an off-by-one occupancy.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
   // status vector bit positions, decoded by the neighbouring register file
   localparam int unsigned ST_W        = 12;
   localparam int unsigned ST_RX_OVF   = 2;
   localparam int unsigned ST_RX_FULL  = 4;
   localparam int unsigned ST_RX_FNXT  = 5;
   localparam int unsigned ST_RX_EMPTY = 6;
   localparam int unsigned ST_RX_ENXT  = 7;
   localparam int unsigned ST_TX_FULL  = 8;
   localparam int unsigned ST_TX_FNXT  = 9;
   localparam int unsigned ST_TX_EMPTY = 10;
   localparam int unsigned ST_TX_ENXT  = 11;

   typedef struct packed {
      logic full;
      logic fnext;
      logic empty;
      logic enext;
   } q_flags_t;
endpackage

// File: rtl/spiq_cfg.sv
module spiq_cfg #(
   parameter int unsigned DW         = 32,
   parameter int unsigned CW         = 6,
   parameter int unsigned LW         = 6,
   parameter int unsigned D_BASE     = 4,
   parameter int unsigned D_NARROW   = 32,
   parameter int unsigned D_MID      = 16,
   parameter int unsigned D_WIDE     = 8,
   parameter int unsigned NARROW_MAX = 8,
   parameter int unsigned MID_MAX    = 16,
   parameter bit          ZEXT       = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic          cfg_big,
   input  logic [LW-1:0] cfg_flen,
   output logic [CW-1:0] depth,
   output logic [DW-1:0] mask
);
   logic [CW-1:0] depth_nx;
   logic [DW-1:0] mask_nx;

   always_comb begin
      if (!cfg_big)
         depth_nx = CW'(D_BASE);
      else if (32'(cfg_flen) <= NARROW_MAX)
         depth_nx = CW'(D_NARROW);
      else if (32'(cfg_flen) <= MID_MAX)
         depth_nx = CW'(D_MID);
      else
         depth_nx = CW'(D_WIDE);
   end

   generate
      if (ZEXT) begin : g_trim
         always_comb begin
            if (cfg_flen == '0 || 32'(cfg_flen) >= DW)
               mask_nx = '1;
            else
               mask_nx = {DW{1'b1}} >> (DW - 32'(cfg_flen));
         end
      end else begin : g_pass
         assign mask_nx = '1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth <= CW'(D_BASE);
         mask  <= '1;
      end else if (cfg_wr) begin
         depth <= depth_nx;
         mask  <= mask_nx;
      end
   end

   // R4
   depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> ($stable(depth) && $stable(mask)));
endmodule

// File: rtl/spiq_ring.sv
module spiq_ring
   import spiq_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned SLOTS = 32,
   parameter int unsigned CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] depth,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          dropped,
   output q_flags_t      flags
);
   localparam int unsigned PW = $clog2(SLOTS);

   logic [DW-1:0] mem [SLOTS];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;

   assign flags.full  = (count >= depth);
   assign flags.fnext = (count == depth - CW'(1));
   assign flags.empty = (count == '0);
   assign flags.enext = (count == CW'(1));

   assign push_ok = wr_en && !flags.full;
   assign pop_ok  = rd_en && !flags.empty;
   assign dropped = wr_en && flags.full;
   assign rd_data = flags.empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + PW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + PW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R5
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && flags.full && !rd_en) |=> $stable(count));
   // R11
   push_pop_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !flags.full && !flags.empty) |=> $stable(count));
   // R7
   last_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.enext && rd_en && !wr_en) |=> flags.empty);
   // R8
   empty_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.empty && rd_en && !wr_en) |=> (flags.empty && $stable(rd_ptr)));
endmodule

// File: rtl/spiq_pair.sv
module spiq_pair
   import spiq_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned SLOTS      = 32,
   parameter int unsigned D_BASE     = 4,
   parameter int unsigned D_NARROW   = 32,
   parameter int unsigned D_MID      = 16,
   parameter int unsigned D_WIDE     = 8,
   parameter int unsigned NARROW_MAX = 8,
   parameter int unsigned MID_MAX    = 16,
   parameter bit          ZEXT       = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic          cfg_big,
   input  logic [5:0]    cfg_flen,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_wdata,
   input  logic          rx_rd,
   output logic [DW-1:0] rx_rdata,
   input  logic          eng_tx_pop,
   output logic [DW-1:0] eng_tx_data,
   input  logic          eng_rx_push,
   input  logic [DW-1:0] eng_rx_data,
   output logic [ST_W-1:0] status
);
   localparam int unsigned CW = $clog2(SLOTS) + 1;
   localparam int unsigned LW = 6;

   generate
      if ((SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("SLOTS must be a power of two");
      end
      if (D_BASE < 2 || D_NARROW > SLOTS || D_MID > SLOTS || D_WIDE > SLOTS || D_BASE > SLOTS) begin : g_bad_depth
         $error("working depths must lie in 2..SLOTS");
      end
      if (NARROW_MAX > MID_MAX) begin : g_bad_bounds
         $error("frame length bounds out of order");
      end
   endgenerate

   logic [CW-1:0] depth;
   logic [DW-1:0] mask;
   logic          rx_drop, tx_drop, ovf;
   q_flags_t      txf, rxf;

   spiq_cfg #(
      .DW(DW), .CW(CW), .LW(LW), .D_BASE(D_BASE), .D_NARROW(D_NARROW),
      .D_MID(D_MID), .D_WIDE(D_WIDE), .NARROW_MAX(NARROW_MAX),
      .MID_MAX(MID_MAX), .ZEXT(ZEXT)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_big(cfg_big),
      .cfg_flen(cfg_flen), .depth(depth), .mask(mask)
   );

   spiq_ring #(.DW(DW), .SLOTS(SLOTS), .CW(CW)) tx_q (
      .clk(clk), .rst_n(rst_n), .depth(depth),
      .wr_en(tx_wr), .wr_data(tx_wdata & mask),
      .rd_en(eng_tx_pop), .rd_data(eng_tx_data),
      .dropped(tx_drop), .flags(txf)
   );

   spiq_ring #(.DW(DW), .SLOTS(SLOTS), .CW(CW)) rx_q (
      .clk(clk), .rst_n(rst_n), .depth(depth),
      .wr_en(eng_rx_push), .wr_data(eng_rx_data & mask),
      .rd_en(rx_rd), .rd_data(rx_rdata),
      .dropped(rx_drop), .flags(rxf)
   );

   // a dropped push wins over a clearing read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (rx_drop) ovf <= 1'b1;
      else if (rx_rd)   ovf <= 1'b0;
   end

   always_comb begin
      status              = '0;
      status[ST_RX_OVF]   = ovf;
      status[ST_RX_FULL]  = rxf.full;
      status[ST_RX_FNXT]  = rxf.fnext;
      status[ST_RX_EMPTY] = rxf.empty;
      status[ST_RX_ENXT]  = rxf.enext;
      status[ST_TX_FULL]  = txf.full;
      status[ST_TX_FNXT]  = txf.fnext;
      status[ST_TX_EMPTY] = txf.empty;
      status[ST_TX_ENXT]  = txf.enext;
   end

   // R9
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rxf.full) |=> status[ST_RX_OVF]);
   // R9
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !(eng_rx_push && rxf.full)) |=> !status[ST_RX_OVF]);
   // R6
   full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({txf.full, txf.fnext, txf.empty}) <= 1);
   // R7
   empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rxf.empty, rxf.enext}) && $onehot0({txf.empty, txf.enext}));
endmodule

// File: tb/spiq_pair_tb.sv
module spiq_pair_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 0, cfg_big = 0;
   logic [5:0]  cfg_flen = '0;
   logic        tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
   logic [31:0] tx_wdata = '0, eng_rx_data = '0;
   logic [31:0] rx_rdata, eng_tx_data;
   logic [11:0] status;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int          depth_m;
   logic [31:0] mask_m;
   logic        ovf_m;
   logic [31:0] txq[$];
   logic [31:0] rxq[$];

   always #4 clk = ~clk;

   spiq_pair dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_big(cfg_big),
      .cfg_flen(cfg_flen), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata), .eng_tx_pop(eng_tx_pop),
      .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
      .eng_rx_data(eng_rx_data), .status(status)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [11:0] exp_status();
      logic [11:0] s = '0;
      int rc = rxq.size(), tc = txq.size();
      s[2]  = ovf_m;
      s[4]  = rc >= depth_m;  s[5]  = rc == depth_m - 1;
      s[6]  = rc == 0;        s[7]  = rc == 1;
      s[8]  = tc >= depth_m;  s[9]  = tc == depth_m - 1;
      s[10] = tc == 0;        s[11] = tc == 1;
      return s;
   endfunction

   task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_status(input string req);
      cmp(req, 32'(status), 32'(exp_status()));
   endtask

   task automatic configure(input logic big, input int fl);
      cfg_big = big; cfg_flen = 6'(fl); cfg_wr = 1;
      @(posedge clk); @(negedge clk);
      cfg_wr = 0;
      depth_m = !big ? 4 : (fl <= 8 ? 32 : (fl <= 16 ? 16 : 8));
      mask_m  = (fl == 0 || fl >= 32) ? 32'hFFFF_FFFF : (32'hFFFF_FFFF >> (32 - fl));
      // R4: disturb the live inputs without a strobe
      cfg_big = ~big; cfg_flen = 6'(fl) ^ 6'd21;
   endtask

   task automatic host_push(input logic [31:0] v);
      tx_wr = 1; tx_wdata = v;
      @(posedge clk); @(negedge clk);
      tx_wr = 0;
      if (txq.size() < depth_m) txq.push_back(v & mask_m);
      chk_status("R5/R6/R2/R3 tx fill");
   endtask

   task automatic eng_pop();
      eng_tx_pop = 1; #1;
      cmp("R8/R10 tx data", eng_tx_data, txq.size() ? txq[0] : 32'h0);
      @(posedge clk); @(negedge clk);
      eng_tx_pop = 0;
      if (txq.size()) void'(txq.pop_front());
      chk_status("R7 tx drain");
   endtask

   task automatic eng_push(input logic [31:0] v);
      eng_rx_push = 1; eng_rx_data = v;
      @(posedge clk); @(negedge clk);
      eng_rx_push = 0;
      if (rxq.size() < depth_m) rxq.push_back(v & mask_m);
      else ovf_m = 1;
      chk_status("R9/R6/R3 rx fill");
   endtask

   task automatic host_read();
      rx_rd = 1; #1;
      cmp("R8/R10 rx data", rx_rdata, rxq.size() ? rxq[0] : 32'h0);
      @(posedge clk); @(negedge clk);
      rx_rd = 0;
      if (rxq.size()) void'(rxq.pop_front());
      ovf_m = 0;
      chk_status("R9/R7 rx drain");
   endtask

   task automatic sweep(input logic big, input int fl);
      configure(big, fl);
      for (int i = 0; i < depth_m + 2; i++)
         host_push(32'hC3A5_0000 ^ (i * 32'h0107_0B13) ^ (fl << 20));
      for (int i = 0; i < depth_m + 1; i++) eng_pop();
      for (int i = 0; i < depth_m + 2; i++)
         eng_push(32'h5A3C_F00F ^ (i * 32'h0305_0709) ^ (fl << 8));
      for (int i = 0; i < depth_m + 1; i++) host_read();
   endtask

   initial begin
      ovf_m = 0; depth_m = 4; mask_m = 32'hFFFF_FFFF;
      #3; @(negedge clk); @(negedge clk);
      // R1: reset state
      cmp("R1 status", 32'(status), 32'h440);
      cmp("R1 rx data", rx_rdata, 32'h0);
      rst_n = 1;
      @(negedge clk);
      // R1: depth 4, full-width words before any configuration
      for (int i = 0; i < 5; i++) host_push(32'hFEDC_BA98 + i);
      for (int i = 0; i < 5; i++) eng_pop();
      // R2: wide option off
      sweep(1'b0, 8);
      // R3, R10: wide option on, every frame length
      for (int fl = 0; fl <= 34; fl++) sweep(1'b1, fl);
      // R11: simultaneous push and pop
      configure(1'b0, 32);
      host_push(32'h1111_1111);
      host_push(32'h2222_2222);
      tx_wr = 1; tx_wdata = 32'h3333_3333; eng_tx_pop = 1; #1;
      cmp("R11 tx data", eng_tx_data, 32'h1111_1111);
      @(posedge clk); @(negedge clk);
      tx_wr = 0; eng_tx_pop = 0;
      void'(txq.pop_front()); txq.push_back(32'h3333_3333);
      chk_status("R11 tx count held");
      eng_rx_push = 1; eng_rx_data = 32'h4444_4444; rx_rd = 1; #1;
      cmp("R11 rx empty read", rx_rdata, 32'h0);
      @(posedge clk); @(negedge clk);
      eng_rx_push = 0; rx_rd = 0;
      rxq.push_back(32'h4444_4444); ovf_m = 0;
      chk_status("R11 rx push on empty read");
      eng_pop(); eng_pop(); host_read();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule